// File: doc/BRIEF.md
# Phase-Lock Monitor with Two-of-Three Vote

This block watches the two divided edges that a frequency synthesiser's phase comparator uses: the divided reference and the divided feedback. Both arrive without a known phase relation to the fast reference clock. Each is first brought into that clock's domain, and a rising edge is detected on each.

When a comparison pair completes, the block works out how far apart the two edges were. The gap is counted in periods of the undivided reference clock. The pair is judged in lock when the gap does not exceed a tolerance that the host selects. The last three judgements are kept in a short history. The reported lock flag follows whatever at least two of those three say, so a single stray miss does not drop the flag.

The flag shows phase agreement within the tolerance. It does not check frequency. Any change of the flag latches a pending bit that the host clears. An interrupt line follows the pending bit unless the host masks it.

Top module: `phase_lock_monitor`

## Requirements
- R1: Each divided input passes through a two-flop synchroniser, and its rising edge is detected after that. The separation of a pair is the number of clock cycles between the two detected edges. Edges detected in the same cycle have a separation of 0.
- R2: A pair counts as locked when its separation is no greater than the tolerance. With `tolWide`=0 the tolerance is 1 cycle, and with `tolWide`=1 it is 4 cycles. Either input may lead.
- R3: A pair counts as unlocked in two cases: a second edge arrives on the same input before the other input's edge, or the other edge has not come within 2^CNT_W-1 cycles (63 by default).
- R4: The history holds the three most recent results. `lockStatus` is 1 exactly when at least two of them are locked. One unlocked result between locked ones does not clear `lockStatus`.
- R5: Reset fills the history with unlocked results. After reset, `lockStatus` rises only once the second locked result has been recorded.
- R6: Any change of `lockStatus` sets `irqPending`. A high `irqClear` clears `irqPending`. If a change and a clear fall in the same cycle, the pending bit is set.
- R7: `irqOut` is high when `irqPending` is 1 and `irqMask` is 0. The mask has no effect on `irqPending`.
- R8: After reset, `lockStatus`, `irqPending` and `irqOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided reference clock, which also serves as the measuring unit |
| rstN | input | 1 | Active-low synchronous reset |
| refDivIn | input | 1 | Divided reference edge input, asynchronous |
| fbDivIn | input | 1 | Divided feedback edge input, asynchronous |
| tolWide | input | 1 | Tolerance select: 0 = 1 cycle, 1 = 4 cycles |
| irqMask | input | 1 | 1 blocks `irqOut` |
| irqClear | input | 1 | Clears the pending flag while high |
| lockStatus | output | 1 | Two-of-three vote over the history |
| irqPending | output | 1 | Sticky flag for a change of the lock status |
| irqOut | output | 1 | Interrupt request |

## Verification
The one cycle in which two functions collide is a change of the voted status while the host is clearing the pending flag. The bench holds `irqClear` high through a whole comparison whose result flips the vote. It then samples in the cycle right after the edge at which the feedback edge is seen. That cycle is three clock edges after the input was driven: two for the synchroniser and one for the recording register. In that cycle the pending bit must read 1, and it must read 0 one cycle later. The tolerance boundaries (1 against 2 cycles, 4 against 5 cycles, with either input leading) are also probed, because the judgement of a pair coincides with the history shift.

// File: rtl/plm_pkg.sv
package plm_pkg;

  // Strobes from control to the separation counter
  typedef struct packed {
    logic cntClear;  // start a new measurement (counter loads 1)
    logic cntInc;    // advance counter by one cycle
  } cnt_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_FB  = 2'd1,
    ST_WAIT_REF = 2'd2
  } meas_state_t;

  function automatic logic vote3(input logic [2:0] h);
    return (h[0] & h[1]) | (h[0] & h[2]) | (h[1] & h[2]);
  endfunction

endpackage

// File: rtl/plm_datapath.sv
module plm_datapath
  import plm_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refDivIn,
  input  logic             fbDivIn,
  input  cnt_strobe_t      cntStrobe,
  output logic             refEdge,
  output logic             fbEdge,
  output logic [CNT_W-1:0] sepCount,
  output logic             sepSat
);
  localparam int NUM_IN = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] edgeVec;

  assign rawIn = {fbDivIn, refDivIn};

  // Synchroniser plus one extra stage for the rising-edge compare
  genvar g;
  generate
    for (g = 0; g < NUM_IN; g++) begin : gSync
      logic [SYNC_STAGES:0] pipe;
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[SYNC_STAGES-1:0], rawIn[g]};
      end
      assign edgeVec[g] = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
    end
  endgenerate

  assign refEdge = edgeVec[0];
  assign fbEdge  = edgeVec[1];

  // Separation counter, saturating at its top value
  always_ff @(posedge clk) begin
    if (!rstN)                                sepCount <= '0;
    else if (cntStrobe.cntClear)              sepCount <= CNT_ONE;
    else if (cntStrobe.cntInc && !sepSat)     sepCount <= sepCount + CNT_ONE;
  end

  assign sepSat = (sepCount == CNT_MAX);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cntStrobe.cntClear, cntStrobe.cntInc})) else $error("strobe clash"); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cntStrobe.cntInc && !sepSat && !cntStrobe.cntClear) |=>
      (sepCount == $past(sepCount) + CNT_ONE)) else $error("count step"); // R1

  AST_CNT_START: assert property (@(posedge clk) disable iff (!rstN)
    cntStrobe.cntClear |=> (sepCount == CNT_ONE)) else $error("count start"); // R1

endmodule

// File: rtl/plm_control.sv
module plm_control
  import plm_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int TOL_NARROW = 1,
  parameter int TOL_WIDE   = 4,
  parameter int HIST_LEN   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refEdge,
  input  logic             fbEdge,
  input  logic [CNT_W-1:0] sepCount,
  input  logic             sepSat,
  input  logic             tolWide,
  input  logic             irqMask,
  input  logic             irqClear,
  output cnt_strobe_t      cntStrobe,
  output logic             lockStatus,
  output logic             irqPending,
  output logic             irqOut
);
  localparam logic [CNT_W-1:0] TOL_N = CNT_W'(TOL_NARROW);
  localparam logic [CNT_W-1:0] TOL_W = CNT_W'(TOL_WIDE);

  meas_state_t state, nextState;
  logic [HIST_LEN-1:0] hist, histNext;
  logic [CNT_W-1:0] tolLimit;
  logic resultValid, resultLock, voteNext;

  assign tolLimit = tolWide ? TOL_W : TOL_N;

  always_comb begin
    nextState   = state;
    resultValid = 1'b0;
    resultLock  = 1'b0;
    cntStrobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (refEdge && fbEdge) begin
          resultValid = 1'b1;
          resultLock  = 1'b1;            // separation 0
        end else if (refEdge) begin
          nextState          = ST_WAIT_FB;
          cntStrobe.cntClear = 1'b1;
        end else if (fbEdge) begin
          nextState          = ST_WAIT_REF;
          cntStrobe.cntClear = 1'b1;
        end
      end
      ST_WAIT_FB: begin
        if (refEdge) begin               // repeated edge on leading input
          resultValid = 1'b1;
          nextState   = ST_IDLE;
        end else if (fbEdge) begin
          resultValid = 1'b1;
          resultLock  = (sepCount <= tolLimit);
          nextState   = ST_IDLE;
        end else if (sepSat) begin
          resultValid = 1'b1;
          nextState   = ST_IDLE;
        end else begin
          cntStrobe.cntInc = 1'b1;
        end
      end
      ST_WAIT_REF: begin
        if (fbEdge) begin
          resultValid = 1'b1;
          nextState   = ST_IDLE;
        end else if (refEdge) begin
          resultValid = 1'b1;
          resultLock  = (sepCount <= tolLimit);
          nextState   = ST_IDLE;
        end else if (sepSat) begin
          resultValid = 1'b1;
          nextState   = ST_IDLE;
        end else begin
          cntStrobe.cntInc = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign histNext = {hist[HIST_LEN-2:0], resultLock};
  assign voteNext = vote3(histNext);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      hist       <= '0;
      lockStatus <= 1'b0;
      irqPending <= 1'b0;
    end else begin
      state <= nextState;
      if (resultValid) begin
        hist       <= histNext;
        lockStatus <= voteNext;
      end
      if (resultValid && (voteNext != lockStatus)) irqPending <= 1'b1;
      else if (irqClear)                          irqPending <= 1'b0;
    end
  end

  assign irqOut = irqPending & ~irqMask;

  AST_ROSE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockStatus) |-> $past(resultValid && resultLock)) else $error("rise w/o lock"); // R4

  AST_FELL_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockStatus) |-> $past(resultValid && !resultLock)) else $error("fall w/o miss"); // R4

  AST_CHANGE_PENDS: assert property (@(posedge clk) disable iff (!rstN)
    (lockStatus != $past(lockStatus)) |-> irqPending) else $error("change not pended"); // R6

  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqPending) |-> $past(irqClear)) else $error("pending lost"); // R6

  AST_SAT_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (sepSat && state != ST_IDLE && !refEdge && !fbEdge) |-> (resultValid && !resultLock))
    else $error("saturation not a miss"); // R3

  AST_NARROW_TOL: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultLock && !tolWide && state != ST_IDLE) |-> (sepCount <= TOL_N))
    else $error("narrow tolerance"); // R2

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
  import plm_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int TOL_NARROW  = 1,
  parameter int TOL_WIDE    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic refDivIn,
  input  logic fbDivIn,
  input  logic tolWide,
  input  logic irqMask,
  input  logic irqClear,
  output logic lockStatus,
  output logic irqPending,
  output logic irqOut
);
  cnt_strobe_t      cntStrobe;
  logic             refEdge, fbEdge, sepSat;
  logic [CNT_W-1:0] sepCount;

  plm_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uDatapath (
    .clk(clk), .rstN(rstN), .refDivIn(refDivIn), .fbDivIn(fbDivIn),
    .cntStrobe(cntStrobe), .refEdge(refEdge), .fbEdge(fbEdge),
    .sepCount(sepCount), .sepSat(sepSat)
  );

  plm_control #(.CNT_W(CNT_W), .TOL_NARROW(TOL_NARROW), .TOL_WIDE(TOL_WIDE), .HIST_LEN(3)) uControl (
    .clk(clk), .rstN(rstN), .refEdge(refEdge), .fbEdge(fbEdge),
    .sepCount(sepCount), .sepSat(sepSat), .tolWide(tolWide),
    .irqMask(irqMask), .irqClear(irqClear), .cntStrobe(cntStrobe),
    .lockStatus(lockStatus), .irqPending(irqPending), .irqOut(irqOut)
  );

endmodule

// File: tb/sim_phase_lock_monitor.sv
module sim_phase_lock_monitor;
  logic clk = 1'b0;
  logic rstN, refDivIn, fbDivIn, tolWide, irqMask, irqClear;
  logic lockStatus, irqPending, irqOut;
  int   nTests = 0;
  int   nFail  = 0;

  always #10 clk = ~clk;   // 50 MHz

  phase_lock_monitor u0 (
    .clk(clk), .rstN(rstN), .refDivIn(refDivIn), .fbDivIn(fbDivIn),
    .tolWide(tolWide), .irqMask(irqMask), .irqClear(irqClear),
    .lockStatus(lockStatus), .irqPending(irqPending), .irqOut(irqOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One comparison pair; sep = cycles between the two rising edges
  task automatic pairRun(input int sep, input bit refFirst);
    @(negedge clk);
    if (sep == 0) begin
      refDivIn = 1'b1; fbDivIn = 1'b1;
    end else begin
      if (refFirst) refDivIn = 1'b1; else fbDivIn = 1'b1;
      idle(sep);
      refDivIn = 1'b1; fbDivIn = 1'b1;
    end
    idle(4);
    refDivIn = 1'b0; fbDivIn = 1'b0;
    idle(6);
  endtask

  task automatic pulseClear();
    @(negedge clk); irqClear = 1'b1;
    @(negedge clk); irqClear = 1'b0;
  endtask

  task automatic pulseOne(input bit onRef);
    @(negedge clk);
    if (onRef) refDivIn = 1'b1; else fbDivIn = 1'b1;
    idle(4);
    refDivIn = 1'b0; fbDivIn = 1'b0;
    idle(4);
  endtask

  task automatic testReset();
    check("R8 status after reset", lockStatus, 0);
    check("R8 pending after reset", irqPending, 0);
    check("R8 irqOut after reset", irqOut, 0);
  endtask

  task automatic testFirstLock();
    pairRun(0, 1'b1);
    check("R5 one lock not enough", lockStatus, 0);
    check("R1 same-cycle pair no pend", irqPending, 0);
    pairRun(1, 1'b1);
    check("R5 second lock sets status", lockStatus, 1);
    check("R6 change sets pending", irqPending, 1);
    check("R7 unmasked irqOut", irqOut, 1);
    pulseClear();
    check("R6 clear drops pending", irqPending, 0);
  endtask

  task automatic testSingleMiss();
    pairRun(2, 1'b1);
    check("R4 isolated miss keeps lock", lockStatus, 1);
    check("R4 no change no pend", irqPending, 0);
    pairRun(2, 1'b0);
    check("R2 sep 2 narrow misses, R4 vote drops", lockStatus, 0);
    check("R6 drop sets pending", irqPending, 1);
    pulseClear();
  endtask

  task automatic testWide();
    tolWide = 1'b1;
    pairRun(4, 1'b0);
    check("R2 wide sep4 fb-first after miss history", lockStatus, 0);
    pairRun(4, 1'b1);
    check("R2 wide sep4 locks", lockStatus, 1);
    pairRun(5, 1'b1);
    check("R2 wide sep5 one miss", lockStatus, 1);
    pairRun(5, 1'b0);
    check("R2 wide sep5 second miss", lockStatus, 0);
    pulseClear();
    tolWide = 1'b0;
  endtask

  task automatic testRepeat();
    pairRun(0, 1'b1);
    pairRun(1, 1'b0);
    check("R2 fb-first sep1 locks", lockStatus, 1);
    pulseClear();
    pulseOne(1'b1);
    pulseOne(1'b1);
    check("R3 repeated ref is a miss (one)", lockStatus, 1);
    pulseOne(1'b0);
    pulseOne(1'b0);
    check("R3 repeated fb is a miss", lockStatus, 0);
    pulseClear();
  endtask

  task automatic testSaturate();
    pairRun(0, 1'b1);
    pairRun(0, 1'b1);
    check("R4 relock", lockStatus, 1);
    pulseClear();
    pulseOne(1'b1); idle(100);
    check("R3 saturation miss one", lockStatus, 1);
    pulseOne(1'b0); idle(100);
    check("R3 saturation misses drop lock", lockStatus, 0);
    pulseClear();
  endtask

  task automatic testMask();
    irqMask = 1'b1;
    pairRun(1, 1'b0);
    pairRun(0, 1'b1);
    check("R7 masked: status", lockStatus, 1);
    check("R7 masked: pending still set", irqPending, 1);
    check("R7 masked: irqOut low", irqOut, 0);
    @(negedge clk); irqMask = 1'b0;
    #1 check("R7 unmask raises irqOut", irqOut, 1);
    pulseClear();
  endtask

  // Status change and clear in the same cycle
  task automatic testCollision();
    pairRun(3, 1'b1);                   // history now locked,locked,miss
    check("R4 one miss still locked", lockStatus, 1);
    @(negedge clk); irqClear = 1'b1;
    refDivIn = 1'b1;
    idle(3);
    fbDivIn = 1'b1;                     // sep 3 > 1 -> second miss
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R6 set wins over clear", irqPending, 1);
    check("R4 status dropped", lockStatus, 0);
    @(negedge clk);
    check("R6 clear acts next cycle", irqPending, 0);
    irqClear = 1'b0;
    refDivIn = 1'b0; fbDivIn = 1'b0;
    idle(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; refDivIn = 1'b0; fbDivIn = 1'b0;
    tolWide = 1'b0; irqMask = 1'b0; irqClear = 1'b0;
    idle(4);
    rstN = 1'b1;
    idle(2);
    testReset();
    testFirstLock();
    testSingleMiss();
    testWide();
    testRepeat();
    testSaturate();
    testMask();
    testCollision();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule